// File: doc/BRIEF.md
# Lockable Security ID Bank

This block holds a small identification area of `2**ADDR_W` bytes, addressed from zero. The lowest `FACT_N` bytes hold a fixed value that is set when the chip is built and can only be read. The bytes above them are a user area. The user area can be programmed in bursts. A lockout command freezes it for good, and only a reset of the block clears that lock.

An upstream deserialiser turns the serial link into byte events. The block receives one byte per `byte_vld` pulse. A `cs_end` pulse marks the end of a frame, and `nib_vld` reports a lone trailing half byte. Three operations are available:

- A streaming read. It takes a start address and a dummy byte, then returns one byte per `rd_req`. The address pointer advances after each byte.
- A program burst. Its bytes are staged while they arrive and are written into the user area when the timed operation finishes.
- A lockout.

Program and lockout take a fixed `PROG_CYCLES` cycles. During that time `busy` stays high. The write-enable latch lives outside the block and enters through `wel`. The block asks the latch to clear through `wel_clr`.

Top module: `sid_bank`

## Requirements
- R1: After reset, `busy`, `wel_clr` and `rd_vld` are 0, every user byte reads FFh, and the area is unlocked.
- R2: The read frame is command byte 88h, then an address byte, then one dummy byte. After that, each cycle with `rd_req` high gives `rd_vld` high one cycle later, with the byte at the pointer on `rd_data`. The pointer then advances by one.
- R3: A read at or past the last address (1Fh by default) returns 00h for every further request until the frame ends. A start address above the last address also reads 00h.
- R4: Addresses 0 to `FACT_N-1` read byte n of `FACTORY_ID`, which is bits [8n+7:8n]. No operation ever changes them.
- R5: The program frame is command byte A5h, then an address byte, then one or more data bytes. When it ends with `wel` high and an address in the user area (08h to 1Fh by default), `busy` goes high for exactly `PROG_CYCLES` cycles. After that, the bytes read back from consecutive addresses starting at the given one.
- R6: A program whose address lies below the user area or past the last address is ignored. It raises no `busy` and changes no byte.
- R7: A program or lockout frame that ends with `wel` low is ignored. It raises no `busy` and changes no byte.
- R8: When a program burst reaches the last address, the bytes beyond it are dropped. Writing does not wrap.
- R9: A lone nibble (`nib_vld`) in a program burst is discarded. The whole bytes before it are still written, and no later byte of that frame is taken.
- R10: The lockout frame is command byte 85h alone. When it ends with `wel` high, `busy` goes high for `PROG_CYCLES` cycles. From then on, every program is ignored and raises no `busy`.
- R11: A frame whose command byte arrives while `busy` is high is ignored in full. A read returns no `rd_vld`, and a program or lockout starts nothing.
- R12: `wel_clr` pulses once per program or lockout, in the last cycle in which `busy` is high.
- R13: A program frame with no data byte is ignored and raises no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_end | input | 1 | Frame end pulse |
| byte_vld | input | 1 | A byte is present on `byte_data` |
| byte_data | input | 8 | Command, address, dummy or data byte |
| nib_vld | input | 1 | A lone trailing nibble was received |
| rd_req | input | 1 | Request the next read byte |
| wel | input | 1 | State of the external write-enable latch |
| rd_vld | output | 1 | `rd_data` holds a read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | A timed program or lockout is running |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The bench builds the block with its default 32-byte map, eight factory bytes and a distinctive `FACTORY_ID`. Because the fixed area uses a distinctive pattern, a byte misplaced between the two areas shows up at once. `PROG_CYCLES` is set to 12, so each timed operation is short and many program, lockout and read frames fit in one run. A 12-cycle window is also long enough to start a second frame while the first operation is still busy. A burst aimed near the top of the map shows the clipping at the last address, and a read started near the top shows the switch to zero fill.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam logic [7:0] CMD_READ = 8'h88;
    localparam logic [7:0] CMD_PROG = 8'hA5;
    localparam logic [7:0] CMD_LOCK = 8'h85;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_RD_ADDR,
        ST_RD_DUMMY,
        ST_RD_DATA,
        ST_PG_ADDR,
        ST_PG_DATA,
        ST_LK_WAIT,
        ST_SKIP
    } frame_st_e;

    typedef enum logic {
        OP_PROG,
        OP_LOCK
    } op_e;

    typedef struct packed {
        logic       we;
        logic       clr;
        logic [7:0] data;
    } stage_t;

endpackage

// File: rtl/sid_frame_dec.sv
module sid_frame_dec
    import sid_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int FACT_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_end,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              nib_vld,
    input  logic              rd_req,
    input  logic              wel,
    input  logic              busy,
    input  logic              locked,
    output logic              start_go,
    output op_e               start_op,
    output stage_t            stage,
    output logic [ADDR_W:0]   stage_ptr,
    output logic              rd_fire,
    output logic [ADDR_W:0]   rd_ptr
);
    localparam int PW = ADDR_W + 1;
    localparam int TOTAL = 1 << ADDR_W;
    localparam logic [8:0] TOTAL_B = 9'(TOTAL);
    localparam logic [8:0] FACT_B = 9'(FACT_N);
    localparam logic [PW-1:0] PTR_END = PW'(TOTAL);

    frame_st_e st_q, st_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic ok_q, ok_d, any_q, any_d, tail_q, tail_d;
    logic addr_in_map, addr_in_user, ptr_at_end;

    assign addr_in_map  = {1'b0, byte_data} < TOTAL_B;
    assign addr_in_user = addr_in_map && ({1'b0, byte_data} >= FACT_B);
    assign ptr_at_end   = (ptr_q == PTR_END);

    always_comb begin
        st_d       = st_q;
        ptr_d      = ptr_q;
        ok_d       = ok_q;
        any_d      = any_q;
        tail_d     = tail_q;
        start_go   = 1'b0;
        start_op   = OP_PROG;
        stage.we   = 1'b0;
        stage.clr  = 1'b0;
        stage.data = byte_data;
        rd_fire    = 1'b0;
        if (cs_end) begin
            st_d   = ST_CMD;
            tail_d = 1'b0;
            if (st_q == ST_PG_DATA && ok_q && any_q && wel && !locked) begin
                start_go = 1'b1;
            end
            if (st_q == ST_LK_WAIT && wel) begin
                start_go = 1'b1;
                start_op = OP_LOCK;
            end
        end else begin
            unique case (st_q)
                ST_CMD: begin
                    if (byte_vld) begin
                        if (busy) begin
                            st_d = ST_SKIP;
                        end else begin
                            unique case (byte_data)
                                CMD_READ: st_d = ST_RD_ADDR;
                                CMD_PROG: st_d = ST_PG_ADDR;
                                CMD_LOCK: st_d = ST_LK_WAIT;
                                default:  st_d = ST_SKIP;
                            endcase
                        end
                    end
                end
                ST_RD_ADDR: begin
                    if (byte_vld) begin
                        ptr_d = addr_in_map ? PW'(byte_data) : PTR_END;
                        st_d  = ST_RD_DUMMY;
                    end
                end
                ST_RD_DUMMY: begin
                    if (byte_vld) st_d = ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    if (rd_req) begin
                        rd_fire = 1'b1;
                        if (!ptr_at_end) ptr_d = ptr_q + PW'(1);
                    end
                end
                ST_PG_ADDR: begin
                    if (byte_vld) begin
                        ok_d      = addr_in_user;
                        any_d     = 1'b0;
                        ptr_d     = addr_in_user ? PW'(byte_data) : PTR_END;
                        stage.clr = 1'b1;
                        st_d      = ST_PG_DATA;
                    end
                end
                ST_PG_DATA: begin
                    if (nib_vld) tail_d = 1'b1;
                    if (byte_vld && ok_q && !ptr_at_end && !tail_q) begin
                        stage.we = 1'b1;
                        any_d    = 1'b1;
                        ptr_d    = ptr_q + PW'(1);
                    end
                end
                ST_LK_WAIT: begin
                    if (byte_vld) st_d = ST_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_CMD;
            ptr_q  <= '0;
            ok_q   <= 1'b0;
            any_q  <= 1'b0;
            tail_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ptr_q  <= ptr_d;
            ok_q   <= ok_d;
            any_q  <= any_d;
            tail_q <= tail_d;
        end
    end

    assign stage_ptr = ptr_q;
    assign rd_ptr    = ptr_q;

    // R8: staged writes never land past the last address
    a_r8_no_stage_past_end: assert property (@(posedge clk) disable iff (rst)
        stage.we |-> (stage_ptr < PTR_END));

endmodule

// File: rtl/sid_busy_timer.sv
module sid_busy_timer
    import sid_pkg::*;
#(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  start_op,
    output logic busy,
    output logic done,
    output op_e  op
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op    <= OP_PROG;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(PROG_CYCLES - 1);
            op    <= start_op;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = busy && (cnt_q == '0);

    // R5: a running operation never restarts
    a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/sid_store.sv
module sid_store
    import sid_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          FACT_N     = 8,
    parameter logic [63:0] FACTORY_ID = 64'h0706050403020100
) (
    input  logic            clk,
    input  logic            rst,
    input  stage_t          stage,
    input  logic [ADDR_W:0] stage_ptr,
    input  logic            commit,
    input  op_e             commit_op,
    input  logic            rd_fire,
    input  logic [ADDR_W:0] rd_ptr,
    output logic            locked,
    output logic            rd_vld,
    output logic [7:0]      rd_data
);
    localparam int PW = ADDR_W + 1;
    localparam int TOTAL = 1 << ADDR_W;
    localparam int USER_N = TOTAL - FACT_N;
    localparam logic [PW-1:0] PTR_END = PW'(TOTAL);

    logic [USER_N*8-1:0] user_flat;
    logic [TOTAL*8-1:0]  all_flat;
    logic [7:0]          rd_byte;

    for (genvar g = 0; g < USER_N; g++) begin : g_cell
        logic [7:0] cell_q, pend_q;
        logic       mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= 8'hFF;
                pend_q <= 8'h00;
                mask_q <= 1'b0;
            end else begin
                if (stage.clr) begin
                    mask_q <= 1'b0;
                end else if (stage.we && stage_ptr == PW'(g + FACT_N)) begin
                    pend_q <= stage.data;
                    mask_q <= 1'b1;
                end
                if (commit && commit_op == OP_PROG && mask_q) cell_q <= pend_q;
            end
        end

        assign user_flat[g*8 +: 8] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst) locked <= 1'b0;
        else if (commit && commit_op == OP_LOCK) locked <= 1'b1;
    end

    assign all_flat = {user_flat, FACTORY_ID[FACT_N*8-1:0]};
    assign rd_byte  = (rd_ptr == PTR_END) ? 8'h00
                    : all_flat[{rd_ptr[ADDR_W-1:0], 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_data <= 8'h00;
        end else begin
            rd_vld  <= rd_fire;
            if (rd_fire) rd_data <= rd_byte;
        end
    end

    // R5: user contents move only at the end of a timed program
    a_r5_commit_only: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(user_flat));
    // R10: once locked, the user area is frozen
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(user_flat));
    // R3: a request at the end pointer yields zero
    a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_ptr == PTR_END) |=> (rd_vld && rd_data == 8'h00));

endmodule

// File: rtl/sid_bank.sv
module sid_bank
    import sid_pkg::*;
#(
    parameter int          ADDR_W      = 5,
    parameter int          FACT_N      = 8,
    parameter int          PROG_CYCLES = 1000,
    parameter logic [63:0] FACTORY_ID  = 64'h0706050403020100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_end,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       nib_vld,
    input  logic       rd_req,
    input  logic       wel,
    output logic       rd_vld,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       wel_clr
);
    stage_t          stage;
    logic [ADDR_W:0] stage_ptr, rd_ptr;
    logic            start_go, rd_fire, done, locked;
    op_e             start_op, run_op;

    sid_frame_dec #(.ADDR_W(ADDR_W), .FACT_N(FACT_N)) dec_i (
        .clk(clk), .rst(rst), .cs_end(cs_end), .byte_vld(byte_vld),
        .byte_data(byte_data), .nib_vld(nib_vld), .rd_req(rd_req), .wel(wel),
        .busy(busy), .locked(locked), .start_go(start_go), .start_op(start_op),
        .stage(stage), .stage_ptr(stage_ptr), .rd_fire(rd_fire), .rd_ptr(rd_ptr)
    );

    sid_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
        .clk(clk), .rst(rst), .start(start_go), .start_op(start_op),
        .busy(busy), .done(done), .op(run_op)
    );

    sid_store #(.ADDR_W(ADDR_W), .FACT_N(FACT_N), .FACTORY_ID(FACTORY_ID)) mem_i (
        .clk(clk), .rst(rst), .stage(stage), .stage_ptr(stage_ptr),
        .commit(done), .commit_op(run_op), .rd_fire(rd_fire), .rd_ptr(rd_ptr),
        .locked(locked), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    assign wel_clr = done;

    // R11: nothing starts while an operation runs
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start_go);
    // R12: busy falls only right after the clear request
    a_r12_clr_before_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(wel_clr));
    // R12: the clear request only appears while busy
    a_r12_clr_in_busy: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> busy);

endmodule

// File: tb/sid_bank_tb_top.sv
module sid_bank_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          PCYC = 12;
    localparam logic [63:0] FID = 64'hF7E6D5C4B3A29180;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_end = 1'b0, byte_vld = 1'b0, nib_vld = 1'b0, rd_req = 1'b0, wel = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic rd_vld, busy, wel_clr;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0, n_unexp = 0;
    logic [7:0] mem [32];
    logic [7:0] expq [$];
    string tagq [$];
    logic [7:0] d [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sid_bank #(.ADDR_W(5), .FACT_N(8), .PROG_CYCLES(PCYC), .FACTORY_ID(FID)) dut_i (
        .clk(clk), .rst(rst), .cs_end(cs_end), .byte_vld(byte_vld),
        .byte_data(byte_data), .nib_vld(nib_vld), .rd_req(rd_req), .wel(wel),
        .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy), .wel_clr(wel_clr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read bytes as the design returns them
    always @(negedge clk) begin
        if (!rst && rd_vld) begin
            if (expq.size() == 0) begin
                n_unexp++;
                chk(1'b0, "R11 unexpected read byte", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(rd_data === e, t, int'(rd_data), int'(e));
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        byte_data = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic end_frame();
        cs_end = 1'b1;
        @(negedge clk);
        cs_end = 1'b0;
    endtask

    task automatic do_read(input int addr, input int n, input string tag, input bit expect_data);
        send_byte(8'h88);
        send_byte(8'(addr));
        send_byte(8'h00);
        for (int i = 0; i < n; i++) begin
            if (expect_data) begin
                expq.push_back((addr + i < 32) ? mem[addr + i] : 8'h00);
                tagq.push_back(tag);
            end
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
        end_frame();
        @(negedge clk);
        chk(expq.size() == 0, {tag, " all read bytes returned"}, expq.size(), 0);
    endtask

    task automatic do_prog(input int addr, input int n, input bit nib);
        send_byte(8'hA5);
        send_byte(8'(addr));
        for (int i = 0; i < n; i++) send_byte(d[i]);
        if (nib) begin
            nib_vld = 1'b1;
            @(negedge clk);
            nib_vld = 1'b0;
        end
        end_frame();
    endtask

    task automatic measure(output int len, output int clr_at, output int clr_n);
        len = 0; clr_at = -1; clr_n = 0;
        while (busy && len < 1000) begin
            if (wel_clr) begin clr_n++; clr_at = len; end
            len++;
            @(negedge clk);
        end
        if (wel_clr) clr_n++;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int len, ca, cn;
        for (int i = 0; i < 32; i++) mem[i] = (i < 8) ? FID[i*8 +: 8] : 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(wel_clr == 1'b0, "R1 wel_clr after reset", int'(wel_clr), 0);
        chk(rd_vld == 1'b0, "R1 rd_vld after reset", int'(rd_vld), 0);
        // R2 R4 R1 streaming read over factory and blank user bytes
        do_read(0, 10, "R2 R4 read from 0", 1'b1);
        // R3 zero fill past the end
        do_read(8'h1D, 6, "R3 read past end", 1'b1);
        do_read(8'h40, 2, "R3 start above map", 1'b1);
        // R5 R12 program
        wel = 1'b1;
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        do_prog(8'h0A, 3, 1'b0);
        measure(len, ca, cn);
        chk(len == PCYC, "R5 busy length", len, PCYC);
        chk(cn == 1, "R12 wel_clr pulse count", cn, 1);
        chk(ca == len - 1, "R12 wel_clr in last busy cycle", ca, len - 1);
        mem[8'h0A] = 8'h11; mem[8'h0B] = 8'h22; mem[8'h0C] = 8'h33;
        do_read(8, 8, "R5 programmed bytes", 1'b1);
        // R7 program without write enable
        wel = 1'b0;
        d[0] = 8'h44;
        do_prog(8'h10, 1, 1'b0);
        measure(len, ca, cn);
        chk(len == 0, "R7 no busy without wel", len, 0);
        do_read(8'h10, 1, "R7 byte unchanged", 1'b1);
        // R6 R4 program into factory area
        wel = 1'b1;
        d[0] = 8'h55; d[1] = 8'h66; d[2] = 8'h77; d[3] = 8'h88;
        do_prog(8'h05, 4, 1'b0);
        measure(len, ca, cn);
        chk(len == 0, "R6 no busy for factory address", len, 0);
        do_read(0, 9, "R6 R4 factory unchanged", 1'b1);
        // R8 burst past the end
        d[0] = 8'hAA; d[1] = 8'hBB; d[2] = 8'hCC; d[3] = 8'hDD;
        do_prog(8'h1E, 4, 1'b0);
        measure(len, ca, cn);
        chk(len == PCYC, "R8 busy length", len, PCYC);
        mem[8'h1E] = 8'hAA; mem[8'h1F] = 8'hBB;
        do_read(8'h1D, 4, "R8 clipped at end", 1'b1);
        do_read(8, 3, "R8 no wrap", 1'b1);
        // R9 trailing nibble
        d[0] = 8'h5A; d[1] = 8'h6B;
        send_byte(8'hA5);
        send_byte(8'h14);
        send_byte(d[0]);
        nib_vld = 1'b1;
        @(negedge clk);
        nib_vld = 1'b0;
        send_byte(d[1]);
        end_frame();
        measure(len, ca, cn);
        chk(len == PCYC, "R9 busy length", len, PCYC);
        mem[8'h14] = 8'h5A;
        do_read(8'h14, 2, "R9 nibble dropped", 1'b1);
        // R13 empty program
        do_prog(8'h16, 0, 1'b0);
        measure(len, ca, cn);
        chk(len == 0, "R13 no busy for empty burst", len, 0);
        // R11 frames while busy
        d[0] = 8'h99;
        do_prog(8'h0C, 1, 1'b0);
        do_read(8'h0C, 2, "R11 read while busy", 1'b0);
        wait_idle();
        mem[8'h0C] = 8'h99;
        d[0] = 8'hC3;
        do_prog(8'h0D, 1, 1'b0);
        d[0] = 8'hE1;
        do_prog(8'h0E, 1, 1'b0);
        wait_idle();
        @(negedge clk);
        chk(busy == 1'b0, "R11 no second operation", int'(busy), 0);
        mem[8'h0D] = 8'hC3;
        do_read(8'h0C, 3, "R11 program while busy ignored", 1'b1);
        chk(n_unexp == 0, "R11 no read output while busy", n_unexp, 0);
        // R7 R10 lockout
        wel = 1'b0;
        send_byte(8'h85);
        end_frame();
        measure(len, ca, cn);
        chk(len == 0, "R7 lockout without wel", len, 0);
        wel = 1'b1;
        send_byte(8'h85);
        end_frame();
        measure(len, ca, cn);
        chk(len == PCYC, "R10 lockout busy length", len, PCYC);
        chk(cn == 1, "R12 wel_clr on lockout", cn, 1);
        d[0] = 8'h42;
        do_prog(8'h18, 1, 1'b0);
        measure(len, ca, cn);
        chk(len == 0, "R10 program after lock", len, 0);
        do_read(8'h18, 1, "R10 locked byte unchanged", 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule